// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block produces the level of one compare output pin of an 8-bit timer. The counter lives elsewhere. It sends this block a compare-match pulse, its counting direction, and strobes for the BOTTOM and TOP events. The block also takes the compare value, the current TOP value, a 2-bit output action field, a 3-bit waveform mode, a timer clock enable and a force strobe. From these it updates a single waveform register. It also raises a pin-ownership signal that tells the port logic the timer drives the pin.

The waveform mode decides how the output action field is read:

- **Non-PWM modes:** the field picks toggle, clear or set on a match.
- **Fast PWM:** the field picks a non-inverting or inverting pair of actions, one at the match and one at BOTTOM.
- **Phase-correct PWM:** the field picks actions that depend on the counting direction.

When the compare value equals TOP in a PWM mode, the match action is suppressed and the level is set at BOTTOM or at TOP instead. A force strobe applies the match action at once, but only outside PWM. The parameter `CHAN_A` selects the first channel, which may toggle in PWM when TOP comes from its own compare register. It is cleared for the second channel, where that encoding is reserved.

Top module: `cmp_wave_unit`

## Requirements
- R1: After reset is asserted, `wave_out` is 0 immediately, and it stays 0 until an action occurs.
- R2: Non-PWM modes are waveform modes whose bit 0 is 0: 000, 010, and the reserved codes 100 and 110. In these modes a match with `tick_en`=1 updates `wave_out` at the next clock edge according to `out_mode`:
  - 01 toggles the output.
  - 10 clears it.
  - 11 sets it.
  - 00 leaves it unchanged.
- R3: Fast PWM is waveform mode 011 or 111. With `out_mode`=10, a match clears the output and `at_bottom` sets it. With `out_mode`=11, a match sets it and `at_bottom` clears it. When a match and `at_bottom` arrive together, the match action wins.
- R4: Phase-correct PWM is waveform mode 001 or 101, and `count_down`=1 means counting down. With `out_mode`=10, a match clears the output while counting up and sets it while counting down. `out_mode`=11 does the reverse.
- R5: In PWM modes, `out_mode`=01 toggles on a match only when `wave_mode[2]`=1 and `CHAN_A`=1. Otherwise the output holds and `pin_own` is 0.
- R6: In PWM modes with `out_mode[1]`=1 and `cmp_val`==`top_val`, a match has no effect. Fast PWM still applies its BOTTOM action. Phase-correct PWM acts on `at_top`: `out_mode`=10 sets the output and 11 clears it.
- R7: In non-PWM modes, `force_cmp`=1 applies the `out_mode` match action at the next clock edge, even when `tick_en`=0.
- R8: In PWM modes, `force_cmp` has no effect on `wave_out`.
- R9: Match, BOTTOM and TOP inputs are ignored while `tick_en`=0.
- R10: `pin_own` is combinational. It is 1 for any nonzero `out_mode`, except the disconnected 01 cases of R5, and 0 for `out_mode`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer clock enable that qualifies event inputs |
| match_pulse | input | 1 | Counter equals compare value |
| count_down | input | 1 | Counter direction, 1 = down |
| at_bottom | input | 1 | Counter BOTTOM event |
| at_top | input | 1 | Counter TOP event |
| out_mode | input | 2 | Output action field |
| wave_mode | input | 3 | Waveform mode |
| cmp_val | input | CNT_W | Compare value of this channel |
| top_val | input | CNT_W | Current TOP value |
| force_cmp | input | 1 | Force-compare strobe |
| wave_out | output | 1 | Waveform level |
| pin_own | output | 1 | Timer owns the pin |

## Verification
The bench targets the points where the reading of `out_mode` changes with the waveform mode.

- **Suppression when the compare value equals TOP.** A design that misses it lets a fast PWM output drop mid-period, or makes a phase-correct output fail to rise at TOP.
- **Match and BOTTOM on the same tick.** If priority is wrong, the match is lost and the output stays high.
- **Force strobe in PWM.** A design that lets the force through flips the PWM output.
- **The 01 encoding.** Wrong decoding either toggles a channel that should be disconnected or claims the pin for it.
- **Reset while running.** Asserting reset mid-run confirms the waveform register clears without waiting for a clock.

// File: rtl/cwu_pkg.sv
package cwu_pkg;

  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,
    WK_FAST  = 2'd1,
    WK_PHASE = 2'd2
  } wave_kind_e;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLR   = 2'd2,
    ACT_TGL   = 2'd3
  } wave_act_e;

  localparam int unsigned WMODE_W = 3;
  localparam int unsigned OMODE_W = 2;

endpackage

// File: rtl/cwu_rst_sync.sv
module cwu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cwu_mode_decode.sv
module cwu_mode_decode
  import cwu_pkg::*;
#(
  parameter bit CHAN_A = 1'b1
) (
  input  logic [WMODE_W-1:0] wave_mode,
  output wave_kind_e         kind,
  output logic               pwm_tgl_ok
);

  always_comb begin
    if (!wave_mode[0])     kind = WK_PLAIN;
    else if (wave_mode[1]) kind = WK_FAST;
    else                   kind = WK_PHASE;
  end

  generate
    if (CHAN_A) begin : g_chan_a
      assign pwm_tgl_ok = wave_mode[2];
    end else begin : g_chan_b
      assign pwm_tgl_ok = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cwu_action_sel.sv
module cwu_action_sel
  import cwu_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n_sync,
  input  wave_kind_e         kind,
  input  logic               pwm_tgl_ok,
  input  logic [OMODE_W-1:0] out_mode,
  input  logic               tick_en,
  input  logic               match_pulse,
  input  logic               count_down,
  input  logic               at_bottom,
  input  logic               at_top,
  input  logic               force_cmp,
  input  logic [CNT_W-1:0]   cmp_val,
  input  logic [CNT_W-1:0]   top_val,
  output wave_act_e          act,
  output logic               own
);

  logic suppress;
  logic ev_match;
  logic ev_bottom;
  logic ev_top;

  assign suppress  = (cmp_val == top_val) && out_mode[1];
  assign ev_match  = tick_en && match_pulse;
  assign ev_bottom = tick_en && at_bottom;
  assign ev_top    = tick_en && at_top;

  always_comb begin
    own = 1'b1;
    if (out_mode == 2'b00) own = 1'b0;
    else if (out_mode == 2'b01 && kind != WK_PLAIN && !pwm_tgl_ok) own = 1'b0;
  end

  always_comb begin
    act = ACT_HOLD;
    unique case (kind)
      WK_PLAIN: begin
        if (ev_match || force_cmp) begin
          unique case (out_mode)
            2'b01:   act = ACT_TGL;
            2'b10:   act = ACT_CLR;
            2'b11:   act = ACT_SET;
            default: act = ACT_HOLD;
          endcase
        end
      end
      WK_FAST: begin
        if (out_mode[1]) begin
          if (ev_match && !suppress) act = out_mode[0] ? ACT_SET : ACT_CLR;
          else if (ev_bottom)        act = out_mode[0] ? ACT_CLR : ACT_SET;
        end else if (out_mode[0] && pwm_tgl_ok && ev_match) begin
          act = ACT_TGL;
        end
      end
      WK_PHASE: begin
        if (out_mode[1]) begin
          if (suppress) begin
            if (ev_top) act = out_mode[0] ? ACT_CLR : ACT_SET;
          end else if (ev_match) begin
            if (count_down) act = out_mode[0] ? ACT_CLR : ACT_SET;
            else            act = out_mode[0] ? ACT_SET : ACT_CLR;
          end
        end else if (out_mode[0] && pwm_tgl_ok && ev_match) begin
          act = ACT_TGL;
        end
      end
      default: act = ACT_HOLD;
    endcase
  end

  // R10: an idle output field never claims the pin
  p_idle_field_no_own_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (out_mode == 2'b00) |-> !own);

  // R8: a PWM mode never turns a lone force strobe into an action
  p_pwm_force_no_act_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (kind != WK_PLAIN && !tick_en && force_cmp) |-> (act == ACT_HOLD));

endmodule

// File: rtl/cwu_wave_reg.sv
module cwu_wave_reg
  import cwu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wave_act_e act,
  output logic      wave_q
);

  logic wave_d;

  always_comb begin
    unique case (act)
      ACT_SET: wave_d = 1'b1;
      ACT_CLR: wave_d = 1'b0;
      ACT_TGL: wave_d = ~wave_q;
      default: wave_d = wave_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wave_q <= 1'b0;
    else if (act != ACT_HOLD)  wave_q <= wave_d;
  end

endmodule

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit
  import cwu_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter bit          CHAN_A = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               match_pulse,
  input  logic               count_down,
  input  logic               at_bottom,
  input  logic               at_top,
  input  logic [OMODE_W-1:0] out_mode,
  input  logic [WMODE_W-1:0] wave_mode,
  input  logic [CNT_W-1:0]   cmp_val,
  input  logic [CNT_W-1:0]   top_val,
  input  logic               force_cmp,
  output logic               wave_out,
  output logic               pin_own
);

  logic       rst_n_sync;
  wave_kind_e kind;
  logic       pwm_tgl_ok;
  wave_act_e  act;

  cwu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cwu_mode_decode #(.CHAN_A(CHAN_A)) u_decode (
    .wave_mode  (wave_mode),
    .kind       (kind),
    .pwm_tgl_ok (pwm_tgl_ok)
  );

  cwu_action_sel #(.CNT_W(CNT_W)) u_action (
    .clk         (clk),
    .rst_n_sync  (rst_n_sync),
    .kind        (kind),
    .pwm_tgl_ok  (pwm_tgl_ok),
    .out_mode    (out_mode),
    .tick_en     (tick_en),
    .match_pulse (match_pulse),
    .count_down  (count_down),
    .at_bottom   (at_bottom),
    .at_top      (at_top),
    .force_cmp   (force_cmp),
    .cmp_val     (cmp_val),
    .top_val     (top_val),
    .act         (act),
    .own         (pin_own)
  );

  cwu_wave_reg u_wave (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .act    (act),
    .wave_q (wave_out)
  );

  // R9: no enable and no strobe means the level holds
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!tick_en && !force_cmp) |=> $stable(wave_out));

  // R8: in PWM modes a force strobe alone leaves the level untouched
  p_pwm_force_stable_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wave_mode[0] && !tick_en) |=> $stable(wave_out));

  // R7: a forced set in a non-PWM mode drives the output high
  p_force_set_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!wave_mode[0] && out_mode == 2'b11 && force_cmp) |=> wave_out);

  // R6: fast PWM with compare at TOP ignores the match
  p_fast_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wave_mode[1:0] == 2'b11 && out_mode[1] && cmp_val == top_val && !at_bottom)
    |=> $stable(wave_out));

endmodule

// File: tb/cmp_wave_unit_tb.sv
module cmp_wave_unit_tb_top;

  localparam int CLK_PER = 10;
  localparam int NV = 28;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, match_pulse, count_down, at_bottom, at_top, force_cmp;
  logic [1:0] out_mode;
  logic [2:0] wave_mode;
  logic [7:0] cmp_val, top_val;
  logic       wave_out, pin_own, wave_b, own_b;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  cmp_wave_unit #(.CNT_W(8), .CHAN_A(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .match_pulse(match_pulse),
    .count_down(count_down), .at_bottom(at_bottom), .at_top(at_top),
    .out_mode(out_mode), .wave_mode(wave_mode), .cmp_val(cmp_val),
    .top_val(top_val), .force_cmp(force_cmp), .wave_out(wave_out), .pin_own(pin_own)
  );

  cmp_wave_unit #(.CNT_W(8), .CHAN_A(1'b0)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .match_pulse(match_pulse),
    .count_down(count_down), .at_bottom(at_bottom), .at_top(at_top),
    .out_mode(out_mode), .wave_mode(wave_mode), .cmp_val(cmp_val),
    .top_val(top_val), .force_cmp(force_cmp), .wave_out(wave_b), .pin_own(own_b)
  );

  // {wave_mode, out_mode, match,down,bottom,top,tick_en,force, cmp, top, exp_wave, exp_own}
  localparam logic [28:0] VEC [NV] = '{
    {3'b000, 2'b11, 6'b100010, 8'h00, 8'h00, 2'b11}, // R2 set
    {3'b000, 2'b10, 6'b100010, 8'h00, 8'h00, 2'b01}, // R2 clear
    {3'b000, 2'b01, 6'b100010, 8'h00, 8'h00, 2'b11}, // R2 toggle
    {3'b010, 2'b01, 6'b100010, 8'h00, 8'h00, 2'b01}, // R2 toggle in CTC
    {3'b010, 2'b01, 6'b100010, 8'h00, 8'h00, 2'b11}, // R2 toggle again
    {3'b000, 2'b00, 6'b100010, 8'h00, 8'h00, 2'b10}, // R10 mode 00 holds, no own
    {3'b000, 2'b10, 6'b100000, 8'h00, 8'h00, 2'b11}, // R9 match without enable
    {3'b000, 2'b10, 6'b000001, 8'h00, 8'h00, 2'b01}, // R7 forced clear
    {3'b000, 2'b11, 6'b000001, 8'h00, 8'h00, 2'b11}, // R7 forced set
    {3'b011, 2'b10, 6'b100010, 8'h80, 8'hFF, 2'b01}, // R3 match clears
    {3'b011, 2'b10, 6'b001010, 8'h80, 8'hFF, 2'b11}, // R3 bottom sets
    {3'b011, 2'b11, 6'b001010, 8'h80, 8'hFF, 2'b01}, // R3 inverting bottom clears
    {3'b011, 2'b11, 6'b100010, 8'h80, 8'hFF, 2'b11}, // R3 inverting match sets
    {3'b011, 2'b10, 6'b101010, 8'h80, 8'hFF, 2'b01}, // R3 coincident: match wins
    {3'b011, 2'b11, 6'b000001, 8'h80, 8'hFF, 2'b01}, // R8 force ignored in fast PWM
    {3'b001, 2'b10, 6'b110010, 8'h40, 8'hFF, 2'b11}, // R4 down match sets
    {3'b001, 2'b10, 6'b100010, 8'h40, 8'hFF, 2'b01}, // R4 up match clears
    {3'b001, 2'b11, 6'b100010, 8'h40, 8'hFF, 2'b11}, // R4 inverted up sets
    {3'b001, 2'b11, 6'b110010, 8'h40, 8'hFF, 2'b01}, // R4 inverted down clears
    {3'b111, 2'b01, 6'b100010, 8'h10, 8'hFF, 2'b11}, // R5 toggle allowed
    {3'b011, 2'b01, 6'b100010, 8'h10, 8'hFF, 2'b10}, // R5 disconnected
    {3'b101, 2'b01, 6'b110010, 8'h10, 8'hFF, 2'b01}, // R5 toggle in phase
    {3'b111, 2'b10, 6'b001010, 8'h99, 8'h99, 2'b11}, // R6 bottom still sets
    {3'b111, 2'b10, 6'b100010, 8'h99, 8'h99, 2'b11}, // R6 match suppressed
    {3'b101, 2'b11, 6'b000110, 8'h50, 8'h50, 2'b01}, // R6 phase clears at TOP
    {3'b101, 2'b11, 6'b100010, 8'h50, 8'h50, 2'b01}, // R6 phase match suppressed
    {3'b101, 2'b10, 6'b000110, 8'h50, 8'h50, 2'b11}, // R6 phase sets at TOP
    {3'b001, 2'b10, 6'b000001, 8'h50, 8'h50, 2'b11}  // R8 force ignored in phase
  };

  localparam int VREQ [NV] = '{2,2,2,2,2,10,9,7,7,3,3,3,3,3,8,4,4,4,4,5,5,5,6,6,6,6,6,8};

  task automatic check(input string req, input logic act_v, input logic exp_v, input string what);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act_v, exp_v);
    end
  endtask

  task automatic idle_inputs();
    tick_en = 0; match_pulse = 0; count_down = 0; at_bottom = 0; at_top = 0; force_cmp = 0;
  endtask

  task automatic drive(input logic [28:0] v);
    @(negedge clk);
    wave_mode = v[28:26]; out_mode = v[25:24];
    match_pulse = v[23]; count_down = v[22]; at_bottom = v[21];
    at_top = v[20]; tick_en = v[19]; force_cmp = v[18];
    cmp_val = v[17:10]; top_val = v[9:2];
    @(posedge clk);
    #(CLK_PER/4);
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; idle_inputs();
    out_mode = 2'b00; wave_mode = 3'b000; cmp_val = 8'h00; top_val = 8'h00;
    repeat (3) @(posedge clk);
    #1 check("R1", wave_out, 1'b0, "reset level");
    check("R10", pin_own, 1'b0, "own with idle field");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1 check("R1", wave_out, 1'b0, "level after release");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check($sformatf("R%0d vec%0d", VREQ[i], i), wave_out, VEC[i][1], "wave");
      check($sformatf("R%0d vec%0d", VREQ[i], i), pin_own, VEC[i][0], "own");
    end

    // R1: asynchronous reset mid-run (wave_out is 1 here)
    @(negedge clk); idle_inputs(); rst_n = 0;
    #1 check("R1", wave_out, 1'b0, "async clear");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    // R2: second channel still toggles in non-PWM
    drive({3'b000, 2'b01, 6'b100010, 8'h10, 8'hFF, 2'b00});
    check("R2", wave_b, 1'b1, "chan B nonpwm toggle");
    check("R10", own_b, 1'b1, "chan B own");
    // R5: second channel, 01 reserved in PWM
    drive({3'b111, 2'b01, 6'b100010, 8'h10, 8'hFF, 2'b00});
    check("R5", wave_b, 1'b1, "chan B reserved hold");
    check("R5", own_b, 1'b0, "chan B reserved own");

    @(negedge clk); idle_inputs();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule